// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block is a clocked master for an open-drain single-wire bus that idles high through an external pull-up resistor. It has two commands. A reset command holds the line low for a long pulse, releases it, and classifies the response: a device answering, an empty bus, or a line stuck low. A touch-byte command runs eight combined write/read time slots, least significant bit first. The line level at a fixed point in each slot is shifted into a receive byte.

The host issues one command at a time while the engine is idle. It then waits for a one-cycle done strobe. After a reset, a presence flag and a fault flag report the result. After a touch byte, the read-data output holds the captured byte.

To read a byte, the host transmits 0xFF. A device can only pull a released slot low, so the line carries the bitwise AND of the master's bit and the device's bit.

All durations are given in microseconds and are turned into cycle counts from a clock-frequency parameter. The line input passes through a two-flop synchronizer before any decision uses it.

Top module: `ow_master`

## Requirements
- R1: A reset command (`cmd_i` = 0) drives the line low for exactly 480 µs of clock cycles and then releases it. When the engine is idle, it never drives the line.
- R2: If the synchronized line is still low 1 µs after the reset pulse is released, the reset completes with `fault_o` = 1 and `presence_o` = 0.
- R3: If the line stays high for 60 µs after that 1 µs check, the reset completes with `presence_o` = 0 and `fault_o` = 0, which means no device is present.
- R4: If a device pulls the line low and the line does not return high within 240 µs, the reset completes with `fault_o` = 1 and `presence_o` = 0.
- R5: After a presence pulse that ends in time, the engine waits 480 µs from the line's return to high. It then completes with `presence_o` = 1 and `fault_o` = 0.
- R6: In every slot of a touch byte (`cmd_i` = 1), the master drives the line low for 2 µs when the bit is 1. When the bit is 0, it holds the line low for 60 µs.
- R7: Each slot samples the line 15 µs after the slot starts. A device pulse that ends before that point reads as 1.
- R8: Write data goes out bit 0 first. Each sampled bit enters at bit 7 of the receive register and moves down one place per slot, so `rd_data_o` bit i is the line level seen in slot i.
- R9: A touch byte with write data 0xFF returns the byte the device sends.
- R10: A command presented while `busy_o` is high is ignored. After the running command completes, the engine stays idle and does not drive the line.
- R11: `busy_o` rises in the cycle after a command is accepted and falls in the cycle in which `done_o` pulses high for exactly one cycle.
- R12: `presence_o` and `fault_o` change only when a reset completes. A touch byte leaves them unchanged.
- R13: Each slot ends with at least 1 µs of released line before the next slot begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request; taken only while idle |
| cmd_i | input | 1 | 0 = bus reset, 1 = touch byte |
| wr_data_i | input | DW | Byte to transmit, sampled when the command is accepted |
| rd_data_o | output | DW | Byte captured by the last touch command |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle strobe when a command completes |
| presence_o | output | 1 | Last reset saw a valid presence pulse |
| fault_o | output | 1 | Last reset found the line stuck low |
| bus_drive_low_o | output | 1 | Enable for the open-drain pull-down |
| bus_line_i | input | 1 | Line level, asynchronous |

## Verification
The bench runs a behavioural bus device that answers resets after a programmable delay and pull length, and pulls zero bits during slots. It applies that device to a short-to-ground case, an empty bus, and a presence pulse that runs beyond the 240 µs limit. A design that merged these outcomes would report presence on a shorted line or call a stuck line an absent device.

Slot checks measure every low pulse the master drives. They cover:
- a pulse that ends before the sampling point, which a sampler placed too late would read as 0;
- mixed write patterns, where a swapped bit order or a missing recovery gap would show up;
- a command issued mid-byte, which a design without an idle-only gate would turn into an unwanted reset after the byte.

// File: rtl/ow_pkg.sv
`timescale 1ns/1ps
package ow_pkg;
  localparam logic CMD_RESET = 1'b0;
  localparam logic CMD_TOUCH = 1'b1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_LOW,
    S_RST_SETTLE,
    S_RST_WAIT_LO,
    S_RST_WAIT_HI,
    S_RST_RECOVER,
    S_SL_LOW,
    S_SL_SAMPLE,
    S_SL_HOLD,
    S_SL_REC
  } ow_state_e;
endpackage

// File: rtl/ow_sync.sv
`timescale 1ns/1ps
module ow_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ow_timer.sv
`timescale 1ns/1ps
module ow_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // state lasts exactly limit_i cycles
  assign expire_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/ow_shift.sv
`timescale 1ns/1ps
module ow_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          capture_i,
  input  logic          line_i,
  input  logic          advance_i,
  output logic          tx_bit_o,
  output logic          last_o,
  output logic [DW-1:0] rx_o
);
  localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] tx_q, rx_q;
  logic [BW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      tx_q  <= data_i;
      idx_q <= '0;
    end else if (advance_i) begin
      tx_q  <= tx_q >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_q <= '0;
    else if (capture_i) rx_q <= {line_i, rx_q[DW-1:1]};
  end

  assign tx_bit_o = tx_q[0];
  assign last_o   = (idx_q == BW'(DW - 1));
  assign rx_o     = rx_q;
endmodule

// File: rtl/ow_master.sv
`timescale 1ns/1ps
module ow_master
  import ow_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          presence_o,
  output logic          fault_o,
  output logic          bus_drive_low_o,
  input  logic          bus_line_i
);
  localparam int unsigned CPU      = CLK_HZ / 1_000_000;
  localparam int unsigned T_RST    = 480 * CPU;
  localparam int unsigned T_SETTLE = 1 * CPU;
  localparam int unsigned T_WLO    = 60 * CPU;
  localparam int unsigned T_WHI    = 240 * CPU;
  localparam int unsigned T_RECOV  = 480 * CPU;
  localparam int unsigned T_SLOW   = 2 * CPU;
  localparam int unsigned T_SSAMP  = 13 * CPU;
  localparam int unsigned T_SHOLD  = 45 * CPU;
  localparam int unsigned T_SREC   = 1 * CPU;
  localparam int unsigned CW       = $clog2(T_RST + 1);

  ow_state_e     state_q, state_d;
  logic [CW-1:0] limit;
  logic          expire, tmr_clr;
  logic          line_s, tx_bit, last_bit;
  logic          fin, fin_rst, pres_n, flt_n;
  logic          done_q, pres_q, flt_q;
  logic          load, capture, advance;

  ow_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(bus_line_i), .q_o(line_s)
  );

  ow_timer #(.CW(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .limit_i(limit), .expire_o(expire)
  );

  ow_shift #(.DW(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .data_i(wr_data_i),
    .capture_i(capture), .line_i(line_s), .advance_i(advance),
    .tx_bit_o(tx_bit), .last_o(last_bit), .rx_o(rd_data_o)
  );

  always_comb begin
    unique case (state_q)
      S_RST_LOW:     limit = CW'(T_RST);
      S_RST_SETTLE:  limit = CW'(T_SETTLE);
      S_RST_WAIT_LO: limit = CW'(T_WLO);
      S_RST_WAIT_HI: limit = CW'(T_WHI);
      S_RST_RECOVER: limit = CW'(T_RECOV);
      S_SL_LOW:      limit = CW'(T_SLOW);
      S_SL_SAMPLE:   limit = CW'(T_SSAMP);
      S_SL_HOLD:     limit = CW'(T_SHOLD);
      S_SL_REC:      limit = CW'(T_SREC);
      default:       limit = CW'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    fin_rst = 1'b0;
    pres_n  = 1'b0;
    flt_n   = 1'b0;
    unique case (state_q)
      S_IDLE: if (cmd_valid_i) state_d = (cmd_i == CMD_RESET) ? S_RST_LOW : S_SL_LOW;
      S_RST_LOW: if (expire) state_d = S_RST_SETTLE;
      S_RST_SETTLE: if (expire) begin
        if (line_s) state_d = S_RST_WAIT_LO;
        else begin fin = 1'b1; fin_rst = 1'b1; flt_n = 1'b1; end  // shorted line
      end
      S_RST_WAIT_LO: begin
        if (!line_s) state_d = S_RST_WAIT_HI;
        else if (expire) begin fin = 1'b1; fin_rst = 1'b1; end    // empty bus
      end
      S_RST_WAIT_HI: begin
        if (line_s) state_d = S_RST_RECOVER;
        else if (expire) begin fin = 1'b1; fin_rst = 1'b1; flt_n = 1'b1; end
      end
      S_RST_RECOVER: if (expire) begin fin = 1'b1; fin_rst = 1'b1; pres_n = 1'b1; end
      S_SL_LOW:    if (expire) state_d = S_SL_SAMPLE;
      S_SL_SAMPLE: if (expire) state_d = S_SL_HOLD;
      S_SL_HOLD:   if (expire) state_d = S_SL_REC;
      S_SL_REC: if (expire) begin
        if (last_bit) fin = 1'b1;
        else          state_d = S_SL_LOW;
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  assign tmr_clr = (state_d != state_q) || (state_q == S_IDLE);
  assign load    = (state_q == S_IDLE) && cmd_valid_i && (cmd_i == CMD_TOUCH);
  assign capture = (state_q == S_SL_SAMPLE) && expire;
  assign advance = (state_q == S_SL_REC) && expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin_rst) begin
        pres_q <= pres_n;
        flt_q  <= flt_n;
      end
    end
  end

  assign busy_o          = (state_q != S_IDLE);
  assign done_o          = done_q;
  assign presence_o      = pres_q;
  assign fault_o         = flt_q;
  assign bus_drive_low_o = (state_q == S_RST_LOW) || (state_q == S_SL_LOW) ||
                           (((state_q == S_SL_SAMPLE) || (state_q == S_SL_HOLD)) && !tx_bit);
endmodule

// File: rtl/ow_master_chk.sv
`timescale 1ns/1ps
module ow_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic presence_o,
  input logic fault_o,
  input logic bus_drive_low_o
);
  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_drive_low_o);

  p_flags_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(presence_o && fault_o));

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i) |=> busy_o);

  p_busy_ends_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_flags_on_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(presence_o) || !$stable(fault_o)) |-> done_o);
endmodule

bind ow_master ow_master_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .presence_o     (presence_o),
  .fault_o        (fault_o),
  .bus_drive_low_o(bus_drive_low_o)
);

// File: tb/ow_master_tb.sv
`timescale 1ns/1ps
module ow_master_tb;
  localparam int CLK_HZ = 4_000_000;  // time-scaled: 4 cycles per microsecond
  localparam int CPU  = CLK_HZ / 1_000_000;
  localparam int T1   = 1 * CPU;
  localparam int T2   = 2 * CPU;
  localparam int T60  = 60 * CPU;
  localparam int T61  = 61 * CPU;
  localparam int T480 = 480 * CPU;
  localparam int NV   = 9;
  // {write byte, device byte, long device pull}
  localparam logic [16:0] VEC [NV] = '{
    {8'hFF, 8'hA5, 1'b1}, {8'hFF, 8'h3C, 1'b1}, {8'h00, 8'hFF, 1'b1},
    {8'h5A, 8'hFF, 1'b1}, {8'h0F, 8'hF0, 1'b1}, {8'h81, 8'hFF, 1'b1},
    {8'hFF, 8'h00, 1'b0}, {8'hFF, 8'h01, 1'b1}, {8'hFF, 8'h80, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic busy, done, presence, fault, drv, bus_line;

  int n_checks = 0, n_err = 0;
  bit dev_present = 1'b0, short_low = 1'b0;
  int dev_pdh = 0, dev_pdl = 0, dev_pull = 0;
  logic [7:0] dev_byte = 8'hFF;
  int pd_wait = 0, pd_run = 0, pull_cnt = 0, run = 0;
  logic [2:0] bit_idx = '0;
  logic drv_q = 1'b0;
  logic dev_low;

  always #2 clk = ~clk;

  assign dev_low  = (pull_cnt > 0) || (pd_run > 0);
  assign bus_line = ~(drv | dev_low | short_low);

  ow_master #(.CLK_HZ(CLK_HZ), .DW(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .busy_o(busy), .done_o(done),
    .presence_o(presence), .fault_o(fault), .bus_drive_low_o(drv), .bus_line_i(bus_line)
  );

  // behavioural bus device
  always @(negedge clk) begin
    drv_q <= drv;
    run   <= drv ? run + 1 : 0;
    if (pull_cnt > 0) pull_cnt <= pull_cnt - 1;
    if (pd_run > 0) pd_run <= pd_run - 1;
    if (pd_wait > 0) begin
      pd_wait <= pd_wait - 1;
      if (pd_wait == 1) pd_run <= dev_pdl;
    end
    if (drv && !drv_q) begin
      if (!dev_byte[bit_idx]) pull_cnt <= dev_pull;
      bit_idx <= bit_idx + 1'b1;
    end
    if (!drv && drv_q && run >= 400 * CPU) begin
      bit_idx  <= '0;
      pull_cnt <= 0;
      if (dev_present) pd_wait <= dev_pdh;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic c, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; wr_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset(input bit present, input int pdh, input int pdl, input bit shorted,
                          output bit pres, output bit flt, output int low_len,
                          output int rel_to_done, output int hi_to_done);
    int t = 0, t_rel = -1, t_hi = -1;
    logic prev_line = 1'b0;
    dev_present = present; dev_pdh = pdh; dev_pdl = pdl; short_low = shorted;
    low_len = 0;
    issue(1'b0, 8'h00);
    while (!done && t < 20000) begin
      if (drv) low_len++;
      else if (t_rel < 0) t_rel = t;
      if (t_rel >= 0 && bus_line && !prev_line) t_hi = t;
      prev_line = bus_line;
      t++;
      @(negedge clk);
    end
    pres = presence; flt = fault;
    rel_to_done = t - t_rel;
    hi_to_done  = t - t_hi;
  endtask

  task automatic do_byte(input logic [7:0] wr, input logic [7:0] dev, input bit long_pull);
    int lows[8];
    int idx = 0, lrun = 0, gap = 0, min_gap = 1 << 30, t = 0, bad = -1;
    logic [7:0] exp;
    bit p0, f0;
    dev_byte = dev;
    dev_pull = long_pull ? 30 * CPU : 10 * CPU;
    p0 = presence; f0 = fault;
    issue(1'b1, wr);
    while (!done && t < 20000) begin
      if (drv) begin
        if (gap > 0 && idx > 0 && gap < min_gap) min_gap = gap;
        gap = 0; lrun++;
      end else begin
        if (lrun > 0) begin
          if (idx < 8) lows[idx] = lrun;
          idx++; lrun = 0;
        end
        gap++;
      end
      t++;
      @(negedge clk);
    end
    check(idx == 8, "R6 slot count", idx, 8);
    for (int i = 0; i < 8; i++)
      if (bad < 0 && lows[i] != (wr[i] ? T2 : T60)) bad = i;
    if (bad >= 0) check(1'b0, "R6 low width", lows[bad], wr[bad] ? T2 : T60);
    else          check(1'b1, "R6 low width", 0, 0);
    check(min_gap >= T1, "R13 recovery gap", min_gap, T1);
    exp = wr & (long_pull ? dev : 8'hFF);
    if (!long_pull)      check(rd_data == exp, "R7 sample point", rd_data, exp);
    else if (wr == 8'hFF) check(rd_data == exp, "R9 read byte", rd_data, exp);
    else                 check(rd_data == exp, "R8 bit order", rd_data, exp);
    check({presence, fault} == {p0, f0}, "R12 flags kept", {presence, fault}, {p0, f0});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    bit p, f;
    int ll, rd, hd, bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, drv} == 3'b000, "R11 reset idle", {busy, done, drv}, 0);
    check({presence, fault} == 2'b00, "R12 reset flags", {presence, fault}, 0);

    do_reset(1'b1, 30 * CPU, 120 * CPU, 1'b0, p, f, ll, rd, hd);
    check(ll == T480, "R1 reset low length", ll, T480);
    check({p, f} == 2'b10, "R5 presence", {p, f}, 2'b10);
    check(hd >= T480 && hd <= T480 + 6, "R5 recovery time", hd, T480);
    @(negedge clk);
    check(!done && !busy, "R11 done single cycle", {done, busy}, 0);

    for (int v = 0; v < NV; v++) do_byte(VEC[v][16:9], VEC[v][8:1], VEC[v][0]);

    // R10: reset request during a byte is dropped
    dev_byte = 8'hFF;
    issue(1'b1, 8'hFF);
    repeat (40) @(negedge clk);
    cmd_valid = 1'b1; cmd = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    check(rd_data == 8'hFF, "R10 byte completes", rd_data, 8'hFF);
    bad = 0;
    repeat (200) begin
      @(negedge clk);
      if (drv || busy) bad++;
    end
    check(bad == 0, "R10 busy command ignored", bad, 0);

    do_reset(1'b0, 0, 0, 1'b0, p, f, ll, rd, hd);
    check({p, f} == 2'b00, "R3 empty bus flags", {p, f}, 0);
    check(rd >= T61 && rd <= T61 + 2, "R3 empty bus time", rd, T61);

    do_reset(1'b0, 0, 0, 1'b1, p, f, ll, rd, hd);
    check({p, f} == 2'b01, "R2 shorted flags", {p, f}, 2'b01);
    check(rd >= T1 && rd <= T1 + 2, "R2 shorted time", rd, T1);
    short_low = 1'b0;
    repeat (10) @(negedge clk);

    do_reset(1'b1, 30 * CPU, 300 * CPU, 1'b0, p, f, ll, rd, hd);
    check({p, f} == 2'b01, "R4 stuck presence", {p, f}, 2'b01);
    repeat (1500) @(negedge clk);

    do_byte(8'hFF, 8'h55, 1'b1);

    do_reset(1'b1, 20 * CPU, 100 * CPU, 1'b0, p, f, ll, rd, hd);
    check({p, f} == 2'b10, "R5 presence again", {p, f}, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule